// File: doc/BRIEF.md
# Receive DMA Ring Buffer Manager

This block places received network frames into a circular region of host memory through a simple word-wide write port. Each frame reaches the block as a start pulse carrying a 16-bit status and a 16-bit byte length, followed by exactly that many data bytes, one per valid cycle. In memory a stored frame is one header word (status in the low half, length in the high half), then the data bytes packed four to a word. The following frame begins on the next 4-byte boundary, and the unused lanes in between are left as holes.

The host claims stored frames through a count register that works as a two-phase handshake. The first read returns how many frames have completed since the previous claim and locks their memory. The next read returns that same number and releases the memory for reuse. A start-of-frame register shows the offset of the oldest frame not yet released. A byte-count register adds up the header and payload bytes of every stored frame. When a frame finishes and the interrupt enable is high, an event bit is set and the interrupt line rises. A frame that would run past the released boundary is discarded as a whole, and a sticky overflow bit records it.

Top module: `rxdma_ring_mgr`

## Requirements
- R1: After reset the interrupt is low, no memory write is issued, and the start-of-frame, byte-count and event registers all read zero.
- R2: A stored frame writes its header word `{length, status}` with all four byte enables, then its data bytes packed so that byte k of the frame lands in lane k mod 4 (bits 8·lane+7..8·lane). The last word enables only its filled lanes, and its unfilled lanes carry zero.
- R3: A frame stored at byte offset S occupies 4 + 4·ceil(len/4) bytes, and the next stored frame starts at the offset just past that. Pad lanes are never written.
- R4: Offsets wrap modulo the ring size (2^ADDR_W bytes), so a frame may continue from the last word of the ring into word 0.
- R5: A count read (register address 0) in the claim phase returns the number of frames completed since the previous claim and resets that number to zero.
- R6: A count read in the release phase returns the number locked by the previous claim and moves the released boundary to the end of those frames. The start-of-frame register (address 2) reads the released boundary's offset.
- R7: A frame is accepted only if 4 + 4·ceil(len/4) is at most the ring size minus the bytes between the released boundary and the write pointer. Otherwise none of its bytes is written, it is not counted, and overflow (event bit 9) is set.
- R8: Count reads alternate strictly between claim and release. A claim that returns zero leaves the claimed and released boundaries where they were.
- R9: A frame completion with the interrupt enable high sets event bit 7 and raises the interrupt on the next cycle. With the enable low it leaves both untouched.
- R10: An event read (address 1) returns bit 7 and bit 9 and clears both, which drops the interrupt.
- R11: The byte-count register (address 3) increases by 4 + len for each stored frame, modulo 2^REG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Enable for the frame-done event and interrupt |
| frm_start | input | 1 | One-cycle pulse that opens a frame |
| frm_status | input | 16 | Frame status, sampled with frm_start |
| frm_len | input | 16 | Frame length in bytes (at least 1), sampled with frm_start |
| byte_valid | input | 1 | A data byte is present on byte_data |
| byte_data | input | 8 | Frame data byte |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 count, 1 event, 2 start-of-frame, 3 byte count |
| reg_rdata | output | REG_W | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt, high while event bit 7 is set |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W-2 | Word address inside the ring |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit n for lane n |

## Verification
The properties rely on the input side keeping its contract. frm_start arrives only when no frame is open, every frame carries a length of at least one, exactly that many byte_valid cycles follow, and byte_valid never appears outside a frame. Register reads are also assumed not to coincide with a frame finishing, so that the count and event values are unambiguous. The bench drives each frame in full, inserting idle gaps between bytes and between frames, and issues every register read only after the last byte of the preceding frame has been taken.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int RX_HALF_W       = 16;
  localparam int RX_WORD_W       = 32;
  localparam int RX_EVT_DONE_BIT = 7;
  localparam int RX_EVT_OVF_BIT  = 9;

  localparam logic [1:0] RA_COUNT = 2'd0;
  localparam logic [1:0] RA_EVENT = 2'd1;
  localparam logic [1:0] RA_SOF   = 2'd2;
  localparam logic [1:0] RA_BYTES = 2'd3;

  typedef enum logic [1:0] {
    ING_IDLE = 2'd0,
    ING_FILL = 2'd1,
    ING_SKIP = 2'd2
  } ing_state_e;

  typedef enum logic {
    PH_CLAIM   = 1'b0,
    PH_RELEASE = 1'b1
  } cnt_phase_e;

  // round a byte count up to whole words
  function automatic logic [31:0] rx_pad4(input logic [31:0] n);
    return (n + 32'd3) & ~32'd3;
  endfunction

  // ring bytes taken by a frame: header word plus padded payload
  function automatic logic [31:0] rx_need(input logic [31:0] len);
    return 32'd4 + rx_pad4(len);
  endfunction

  // insert a byte into its lane of a packing word
  function automatic logic [31:0] rx_lane_put(input logic [31:0] word,
                                              input logic [1:0]  lane,
                                              input logic [7:0]  b);
    logic [31:0] r;
    r = word;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [3:0] rx_be_put(input logic [3:0] be,
                                           input logic [1:0] lane);
    logic [3:0] r;
    r = be;
    r[lane] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/rxdma_ingest.sv
module rxdma_ingest
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_start,
  input  logic [RX_HALF_W-1:0]  frm_status,
  input  logic [RX_HALF_W-1:0]  frm_len,
  input  logic                  byte_valid,
  input  logic [7:0]            byte_data,
  input  logic [ADDR_W-1:0]     wr_off,
  input  logic [ADDR_W:0]       free_bytes,
  output logic                  mem_we,
  output logic [ADDR_W-3:0]     mem_addr,
  output logic [RX_WORD_W-1:0]  mem_wdata,
  output logic [3:0]            mem_be,
  output logic                  frame_accept,
  output logic                  frame_drop,
  output logic                  frame_done,
  output logic [ADDR_W:0]       done_need,
  output logic [RX_HALF_W-1:0]  done_len,
  output logic                  filling
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  ing_state_e             st_q;
  logic [RX_HALF_W-1:0]   remain_q;
  logic [ADDR_W-1:0]      cur_q;
  logic [1:0]             lane_q;
  logic [RX_WORD_W-1:0]   pack_q;
  logic [3:0]             pbe_q;
  logic [ADDR_W:0]        need_q;
  logic [RX_HALF_W-1:0]   len_q;

  logic [31:0]            need_full;
  logic                   fits;
  logic                   last_byte;
  logic                   emit;
  logic [RX_WORD_W-1:0]   word_n;
  logic [3:0]             be_n;

  always_comb begin
    need_full    = rx_need({16'd0, frm_len});
    fits         = need_full <= {{(31-ADDR_W){1'b0}}, free_bytes};
    frame_accept = (st_q == ING_IDLE) && frm_start && fits;
    frame_drop   = (st_q == ING_IDLE) && frm_start && !fits;
    last_byte    = byte_valid && (st_q != ING_IDLE) && (remain_q == 16'd1);
    frame_done   = (st_q == ING_FILL) && last_byte;
    emit         = (st_q == ING_FILL) && byte_valid &&
                   ((lane_q == 2'd3) || (remain_q == 16'd1));
    word_n       = rx_lane_put(pack_q, lane_q, byte_data);
    be_n         = rx_be_put(pbe_q, lane_q);
  end

  assign done_need = need_q;
  assign done_len  = len_q;
  assign filling   = (st_q == ING_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ING_IDLE;
      remain_q  <= '0;
      cur_q     <= '0;
      lane_q    <= '0;
      pack_q    <= '0;
      pbe_q     <= '0;
      need_q    <= '0;
      len_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st_q)
        ING_IDLE: begin
          if (frame_accept) begin
            mem_we    <= 1'b1;
            mem_addr  <= wr_off[ADDR_W-1:2];
            mem_wdata <= {frm_len, frm_status};
            mem_be    <= 4'hF;
            cur_q     <= wr_off + WORD_STEP;
            remain_q  <= frm_len;
            lane_q    <= 2'd0;
            pack_q    <= '0;
            pbe_q     <= '0;
            need_q    <= need_full[ADDR_W:0];
            len_q     <= frm_len;
            st_q      <= ING_FILL;
          end else if (frame_drop) begin
            remain_q  <= frm_len;
            st_q      <= ING_SKIP;
          end
        end
        ING_FILL: begin
          if (byte_valid) begin
            remain_q <= remain_q - 16'd1;
            lane_q   <= lane_q + 2'd1;
            if (emit) begin
              mem_we    <= 1'b1;
              mem_addr  <= cur_q[ADDR_W-1:2];
              mem_wdata <= word_n;
              mem_be    <= be_n;
              cur_q     <= cur_q + WORD_STEP;
              pack_q    <= '0;
              pbe_q     <= '0;
            end else begin
              pack_q    <= word_n;
              pbe_q     <= be_n;
            end
            if (remain_q == 16'd1) st_q <= ING_IDLE;
          end
        end
        ING_SKIP: begin
          if (byte_valid) begin
            remain_q <= remain_q - 16'd1;
            if (remain_q == 16'd1) st_q <= ING_IDLE;
          end
        end
        default: st_q <= ING_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxdma_ring_ctl.sv
module rxdma_ring_ctl
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [ADDR_W:0]   done_need,
  input  logic              rd_count,
  output logic              rd_claim,
  output logic              rd_release,
  output logic [ADDR_W:0]   wr_ptr,
  output logic [ADDR_W:0]   free_ptr,
  output logic [ADDR_W:0]   claim_ptr,
  output logic [ADDR_W:0]   used_bytes,
  output logic [ADDR_W:0]   free_bytes,
  output logic              phase,
  output logic              pend_nz,
  output logic [REG_W-1:0]  cnt_rdata
);

  localparam logic [ADDR_W:0] RING_BYTES = {1'b1, {ADDR_W{1'b0}}};

  cnt_phase_e        phase_q;
  logic [ADDR_W:0]   wr_q;
  logic [ADDR_W:0]   free_q;
  logic [ADDR_W:0]   claim_q;
  logic [REG_W-1:0]  pend_q;
  logic [REG_W-1:0]  claimed_q;

  always_comb begin
    rd_claim   = rd_count && (phase_q == PH_CLAIM);
    rd_release = rd_count && (phase_q == PH_RELEASE);
    used_bytes = wr_q - free_q;
    free_bytes = RING_BYTES - used_bytes;
    cnt_rdata  = (phase_q == PH_CLAIM) ? pend_q : claimed_q;
  end

  assign wr_ptr    = wr_q;
  assign free_ptr  = free_q;
  assign claim_ptr = claim_q;
  assign phase     = phase_q;
  assign pend_nz   = (pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CLAIM;
      wr_q      <= '0;
      free_q    <= '0;
      claim_q   <= '0;
      pend_q    <= '0;
      claimed_q <= '0;
    end else begin
      if (frame_done) wr_q <= wr_q + done_need;

      if (rd_claim)        pend_q <= frame_done ? REG_W'(1) : '0;
      else if (frame_done) pend_q <= pend_q + REG_W'(1);

      if (rd_claim) begin
        claimed_q <= pend_q;
        if (pend_q != '0) claim_q <= wr_q;
        phase_q   <= PH_RELEASE;
      end
      if (rd_release) begin
        free_q    <= claim_q;
        claimed_q <= '0;
        phase_q   <= PH_CLAIM;
      end
    end
  end

endmodule

// File: rtl/rxdma_host_regs.sv
module rxdma_host_regs
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int REG_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_en,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic                 frame_done,
  input  logic [RX_HALF_W-1:0] done_len,
  input  logic                 frame_drop,
  input  logic [REG_W-1:0]     cnt_rdata,
  input  logic [ADDR_W-1:0]    sof,
  output logic                 rd_count,
  output logic                 rd_event,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq,
  output logic                 evt_ovf
);

  logic             evt_q;
  logic             ovf_q;
  logic [REG_W-1:0] bytes_q;
  logic [REG_W-1:0] event_word;

  always_comb begin
    rd_count   = reg_rd && (reg_addr == RA_COUNT);
    rd_event   = reg_rd && (reg_addr == RA_EVENT);
    event_word = '0;
    event_word[RX_EVT_DONE_BIT] = evt_q;
    event_word[RX_EVT_OVF_BIT]  = ovf_q;
  end

  assign irq     = evt_q;
  assign evt_ovf = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q     <= 1'b0;
      ovf_q     <= 1'b0;
      bytes_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (frame_done && irq_en) evt_q <= 1'b1;
      else if (rd_event)        evt_q <= 1'b0;

      if (frame_drop)    ovf_q <= 1'b1;
      else if (rd_event) ovf_q <= 1'b0;

      if (frame_done) bytes_q <= bytes_q + REG_W'(done_len) + REG_W'(4);

      if (reg_rd) begin
        case (reg_addr)
          RA_COUNT: reg_rdata <= cnt_rdata;
          RA_EVENT: reg_rdata <= event_word;
          RA_SOF:   reg_rdata <= REG_W'(sof);
          default:  reg_rdata <= bytes_q;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxdma_ring_mgr.sv
module rxdma_ring_mgr
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              frm_start,
  input  logic [15:0]       frm_status,
  input  logic [15:0]       frm_len,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be
);

  // named internal events for the bound checker
  logic                 ev_frame_accept;
  logic                 ev_frame_drop;
  logic                 ev_frame_done;
  logic                 ev_rd_count;
  logic                 ev_rd_claim;
  logic                 ev_rd_release;
  logic                 ev_rd_event;
  logic                 ing_filling;
  logic [ADDR_W:0]      wr_ptr_w;
  logic [ADDR_W:0]      free_ptr_w;
  logic [ADDR_W:0]      claim_ptr_w;
  logic [ADDR_W:0]      ring_used_w;
  logic [ADDR_W:0]      ring_free_w;
  logic                 phase_w;
  logic                 pend_nz_w;
  logic                 evt_ovf_w;
  logic [ADDR_W:0]      done_need_w;
  logic [15:0]          done_len_w;
  logic [REG_W-1:0]     cnt_rdata_w;

  rxdma_ingest #(.ADDR_W(ADDR_W)) ingest_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_start    (frm_start),
    .frm_status   (frm_status),
    .frm_len      (frm_len),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .wr_off       (wr_ptr_w[ADDR_W-1:0]),
    .free_bytes   (ring_free_w),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_be       (mem_be),
    .frame_accept (ev_frame_accept),
    .frame_drop   (ev_frame_drop),
    .frame_done   (ev_frame_done),
    .done_need    (done_need_w),
    .done_len     (done_len_w),
    .filling      (ing_filling)
  );

  rxdma_ring_ctl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) ring_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (ev_frame_done),
    .done_need  (done_need_w),
    .rd_count   (ev_rd_count),
    .rd_claim   (ev_rd_claim),
    .rd_release (ev_rd_release),
    .wr_ptr     (wr_ptr_w),
    .free_ptr   (free_ptr_w),
    .claim_ptr  (claim_ptr_w),
    .used_bytes (ring_used_w),
    .free_bytes (ring_free_w),
    .phase      (phase_w),
    .pend_nz    (pend_nz_w),
    .cnt_rdata  (cnt_rdata_w)
  );

  rxdma_host_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .frame_done (ev_frame_done),
    .done_len   (done_len_w),
    .frame_drop (ev_frame_drop),
    .cnt_rdata  (cnt_rdata_w),
    .sof        (free_ptr_w[ADDR_W-1:0]),
    .rd_count   (ev_rd_count),
    .rd_event   (ev_rd_event),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .evt_ovf    (evt_ovf_w)
  );

endmodule

// File: rtl/rxdma_ring_mgr_chk.sv
module rxdma_ring_mgr_chk #(
  parameter int ADDR_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_en,
  input logic            irq,
  input logic            mem_we,
  input logic            ev_frame_accept,
  input logic            ev_frame_drop,
  input logic            ev_frame_done,
  input logic            ev_rd_claim,
  input logic            ev_rd_release,
  input logic            ev_rd_event,
  input logic            ing_filling,
  input logic [ADDR_W:0] wr_ptr_w,
  input logic [ADDR_W:0] free_ptr_w,
  input logic [ADDR_W:0] claim_ptr_w,
  input logic [ADDR_W:0] ring_used_w,
  input logic            phase_w,
  input logic            pend_nz_w,
  input logic            evt_ovf_w
);

  localparam logic [ADDR_W:0] RING_BYTES = {1'b1, {ADDR_W{1'b0}}};

  // R7
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_used_w <= RING_BYTES);

  // R7
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_drop |=> !mem_we);

  // R7
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_drop |=> evt_ovf_w);

  // R1
  write_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_frame_accept || ing_filling) |=> !mem_we);

  // R3
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr_w[1:0] == 2'b00);

  // R9
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_done && irq_en) |=> irq);

  // R10
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_event && !(ev_frame_done && irq_en)) |=> !irq);

  // R8
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_claim || ev_rd_release) |=> (phase_w != $past(phase_w)));

  // R8
  zero_claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_claim && !pend_nz_w) |=> $stable(claim_ptr_w));

  // R6
  free_only_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd_release |=> $stable(free_ptr_w));

  // R5
  claim_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd_claim |=> $stable(claim_ptr_w));

endmodule

bind rxdma_ring_mgr rxdma_ring_mgr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .irq_en          (irq_en),
  .irq             (irq),
  .mem_we          (mem_we),
  .ev_frame_accept (ev_frame_accept),
  .ev_frame_drop   (ev_frame_drop),
  .ev_frame_done   (ev_frame_done),
  .ev_rd_claim     (ev_rd_claim),
  .ev_rd_release   (ev_rd_release),
  .ev_rd_event     (ev_rd_event),
  .ing_filling     (ing_filling),
  .wr_ptr_w        (wr_ptr_w),
  .free_ptr_w      (free_ptr_w),
  .claim_ptr_w     (claim_ptr_w),
  .ring_used_w     (ring_used_w),
  .phase_w         (phase_w),
  .pend_nz_w       (pend_nz_w),
  .evt_ovf_w       (evt_ovf_w)
);

// File: tb/rxdma_ring_mgr_tb_top.sv
`timescale 1ns/1ps
module rxdma_ring_mgr_tb_top;

  localparam int AW   = 8;
  localparam int RING = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_en = 1'b0;
  logic        frm_start = 1'b0;
  logic [15:0] frm_status = '0;
  logic [15:0] frm_len = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        mem_we;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;

  rxdma_ring_mgr #(.ADDR_W(AW), .REG_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .frm_start(frm_start), .frm_status(frm_status), .frm_len(frm_len),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // scoreboard of expected memory writes
  int          q_addr[$];
  logic [31:0] q_data[$];
  logic [3:0]  q_be[$];
  string       q_tag[$];

  // reference state, byte positions kept as unbounded totals
  int m_wt = 0, m_ft = 0, m_ct = 0;
  int m_pend = 0, m_cmt = 0, m_bytes = 0;
  bit m_release = 0, m_evt = 0, m_ovf = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((seed + i * 37) & 255);
  endfunction

  // monitor: pops one expectation per observed write
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R7", "unexpected memory write addr", longint'(mem_addr), -1);
      end else begin
        int          ea;
        logic [31:0] ed;
        logic [3:0]  eb;
        string       et;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        eb = q_be.pop_front();
        et = q_tag.pop_front();
        chk(int'(mem_addr) == ea, et, "write word address", longint'(mem_addr), ea);
        chk(mem_wdata == ed, "R2", "write data", longint'(mem_wdata), longint'(ed));
        chk(mem_be == eb, "R2", "byte enables", longint'(mem_be), longint'(eb));
      end
    end
  end

  task automatic send_frame(input int status, input int len, input int seed,
                            input int gap);
    int need;
    need = 4 + ((len + 3) / 4) * 4;
    if (need <= RING - (m_wt - m_ft)) begin
      string tag;
      tag = (((m_wt % RING) + need) > RING) ? "R4" : "R3";
      q_addr.push_back((m_wt % RING) / 4);
      q_data.push_back({16'(len), 16'(status)});
      q_be.push_back(4'hF);
      q_tag.push_back(tag);
      for (int w = 0; w < (len + 3) / 4; w++) begin
        logic [31:0] d;
        logic [3:0]  b;
        d = '0;
        b = '0;
        for (int l = 0; l < 4; l++) begin
          if (w * 4 + l < len) begin
            d[l*8 +: 8] = byte_of(seed, w * 4 + l);
            b[l] = 1'b1;
          end
        end
        q_addr.push_back(((m_wt + 4 + 4 * w) % RING) / 4);
        q_data.push_back(d);
        q_be.push_back(b);
        q_tag.push_back(tag);
      end
      m_wt += need;
      m_pend++;
      m_bytes = (m_bytes + 4 + len) & 16'hFFFF;
      if (irq_en) m_evt = 1;
    end else begin
      m_ovf = 1;
    end
    @(posedge clk); #1;
    frm_start = 1'b1; frm_status = 16'(status); frm_len = 16'(len);
    @(posedge clk); #1;
    frm_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      byte_valid = 1'b1;
      byte_data = byte_of(seed, i);
      @(posedge clk); #1;
      byte_valid = 1'b0;
      if (gap > 0 && (i % gap) == gap - 1 && i != len - 1) begin
        @(posedge clk); #1;
      end
    end
    byte_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int v);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic rd_count_chk(input string req);
    int v, e;
    if (!m_release) begin
      e = m_pend;
      if (m_pend != 0) m_ct = m_wt;
      m_cmt = m_pend;
      m_pend = 0;
      m_release = 1;
    end else begin
      e = m_cmt;
      m_ft = m_ct;
      m_cmt = 0;
      m_release = 0;
    end
    rd_reg(2'd0, v);
    chk(v == e, req, "frame count read", v, e);
  endtask

  task automatic rd_event_chk(input string req);
    int v, e;
    e = (int'(m_evt) << 7) | (int'(m_ovf) << 9);
    rd_reg(2'd1, v);
    m_evt = 0;
    m_ovf = 0;
    chk(v == e, req, "event read", v, e);
  endtask

  task automatic rd_sof_chk(input string req);
    int v, e;
    e = m_ft % RING;
    rd_reg(2'd2, v);
    chk(v == e, req, "start-of-frame read", v, e);
  endtask

  task automatic rd_bytes_chk(input string req);
    int v;
    rd_reg(2'd3, v);
    chk(v == m_bytes, req, "byte count read", v, m_bytes);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    chk(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
    rd_sof_chk("R1");
    rd_bytes_chk("R1");
    rd_event_chk("R1");
    // R8: zero claim then release from reset
    rd_count_chk("R8");
    rd_count_chk("R8");
    rd_sof_chk("R8");

    // R2 R3 R9: first frames with interrupt enabled
    irq_en = 1'b1;
    send_frame(16'h1234, 5, 11, 0);
    chk(irq == 1'b1, "R9", "irq after frame done", irq, 1);
    rd_event_chk("R10");
    chk(irq == 1'b0, "R10", "irq after event read", irq, 0);
    send_frame(16'hBEEF, 8, 3, 2);
    send_frame(16'h0042, 3, 90, 1);

    // R5 R6: claim three, one more arrives, release, claim the new one
    rd_count_chk("R5");
    send_frame(16'h7777, 10, 200, 3);
    rd_count_chk("R6");
    rd_sof_chk("R6");
    rd_count_chk("R5");
    rd_count_chk("R6");
    rd_sof_chk("R6");

    // R8: zero claim leaves the boundary alone
    rd_count_chk("R8");
    rd_sof_chk("R8");
    rd_count_chk("R8");
    rd_sof_chk("R8");

    // R7: fill the ring exactly, then overflow
    send_frame(16'h0101, 60, 5, 0);
    send_frame(16'h0202, 60, 6, 4);
    send_frame(16'h0303, 60, 7, 0);
    send_frame(16'h0404, 60, 8, 0);
    send_frame(16'h0505, 1, 9, 0);
    rd_event_chk("R7");
    rd_count_chk("R7");
    rd_count_chk("R6");
    rd_sof_chk("R6");

    // R4: a frame that runs past the end of the ring
    send_frame(16'h0A0A, 200, 17, 5);
    send_frame(16'h0B0B, 30, 23, 0);
    send_frame(16'h0C0C, 20, 29, 0);
    rd_event_chk("R7");
    rd_count_chk("R5");
    rd_count_chk("R6");
    rd_sof_chk("R4");

    // R9: completion with the enable low
    irq_en = 1'b0;
    send_frame(16'h0D0D, 2, 31, 0);
    chk(irq == 1'b0, "R9", "irq with enable low", irq, 0);
    rd_event_chk("R9");
    rd_bytes_chk("R11");

    repeat (3) @(posedge clk); #1;
    chk(q_addr.size() == 0, "R2", "writes left outstanding", q_addr.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule